// File: doc/BRIEF.md
# Leveled Priority Interrupt Controller

This block gathers interrupt flags from a bank of peripheral sources and keeps one request in front of the processor. Each source has its own programmable priority level. Its vector number is its index in the flag bus. On every clock the block picks one winner from the sources that are pending and have a non-zero level. It drives a request line, the winner's level and the winner's vector number from registers.

A source becomes pending when its flag rises. It stays pending while its flag is high, until the processor acknowledges it. If the peripheral drops the flag first, the request is cancelled. A higher-priority cause that arrives before the acknowledge replaces the request being shown, and the earlier cause stays pending. After an acknowledge, the next winner appears at once. The level registers are loaded through a single-entry write port.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Each source owns a 3-bit level register. It is loaded from `cfg_lvl` when `cfg_we` is high and `cfg_idx` selects it. A write takes effect on the outputs at the same clock edge that captures it.
- R2: After reset, every level register is 0 and nothing is pending. `irq_req`, `irq_lvl` and `irq_vec` are all 0.
- R3: A source whose level is 0 is never shown. Whenever `irq_req` is 1, `irq_lvl` is non-zero.
- R4: Among the shown candidates (pending and non-zero level), the one with the numerically largest level wins. 7 is the highest level.
- R5: When several candidates share the largest level, the one with the smallest index wins. `irq_vec` equals the winner's index in `src_flag`.
- R6: A source becomes pending on a 0-to-1 change of its flag. A source that loses arbitration stays pending until it is shown and acknowledged.
- R7: When a higher-priority cause becomes pending before the shown request is acknowledged, `irq_lvl` and `irq_vec` switch to it on that edge. The earlier source stays pending.
- R8: A pending source whose flag is low at a clock edge is dropped at that edge and is never shown afterwards.
- R9: A one-cycle `irq_ack` with `irq_req` high clears the source shown at that moment, and the next winner is shown at the same edge. The acknowledged source is not pending again until its flag falls and rises again.
- R10: The outputs are registered and reflect flags, writes and acknowledges sampled at the latest clock edge. With no candidate, all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_flag | input | NUM_SRC | Peripheral interrupt flags, bit i is vector i |
| cfg_we | input | 1 | Level register write strobe |
| cfg_idx | input | VEC_W | Source selected for the write |
| cfg_lvl | input | LVL_W | Level value to write |
| irq_ack | input | 1 | Processor acknowledge, one-cycle pulse |
| irq_req | output | 1 | Request to the processor |
| irq_lvl | output | LVL_W | Level of the shown request |
| irq_vec | output | VEC_W | Vector number of the shown request |

## Verification
The assertions check four invariants on every cycle. A shown request never carries level 0. The shown vector is always pending and its level matches the register. No pending source survives an edge at which its flag was low. An acknowledged source is gone on the next cycle. Arbitration order, live preemption, the draining order of held causes and the write-to-output timing are shown only by the bench. It sweeps every source across every level, drains tied groups through acknowledge, and compares the outputs against an independent model during a long pseudo-random run.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
    localparam int DEF_NUM_SRC = 32;
    localparam int DEF_LVL_W   = 3;
endpackage

// File: rtl/irq_level_file.sv
module irq_level_file #(
    parameter int N    = 32,
    parameter int LW   = 3,
    parameter int VW   = 5
) (
    input  logic [N*LW-1:0] lvl_q,
    input  logic            we,
    input  logic [VW-1:0]   idx,
    input  logic [LW-1:0]   val,
    output logic [N*LW-1:0] lvl_d
);
    always_comb begin
        lvl_d = lvl_q;
        for (int i = 0; i < N; i++) begin
            if (we && (int'(idx) == i)) begin
                lvl_d[i*LW +: LW] = val;
            end
        end
    end
endmodule

// File: rtl/irq_pend_next.sv
module irq_pend_next #(
    parameter int N  = 32,
    parameter int VW = 5
) (
    input  logic [N-1:0]  pend_q,
    input  logic [N-1:0]  flag,
    input  logic [N-1:0]  flag_prev,
    input  logic          ack,
    input  logic          shown_req,
    input  logic [VW-1:0] shown_vec,
    output logic [N-1:0]  pend_d
);
    logic [N-1:0] clr;

    always_comb begin
        clr = '0;
        for (int i = 0; i < N; i++) begin
            clr[i] = ack && shown_req && (int'(shown_vec) == i);
        end
        pend_d = (pend_q | (flag & ~flag_prev)) & flag & ~clr;
    end
endmodule

// File: rtl/irq_arb.sv
module irq_arb #(
    parameter int N  = 32,
    parameter int LW = 3,
    parameter int VW = 5
) (
    input  logic [N-1:0]    pend,
    input  logic [N*LW-1:0] lvl,
    output logic            win,
    output logic [LW-1:0]   win_lvl,
    output logic [VW-1:0]   win_vec
);
    logic [LW-1:0] cur;

    always_comb begin
        win     = 1'b0;
        win_lvl = '0;
        win_vec = '0;
        cur     = '0;
        for (int i = N - 1; i >= 0; i--) begin
            cur = lvl[i*LW +: LW];
            if (pend[i] && (cur != '0) && (cur >= win_lvl)) begin
                win     = 1'b1;
                win_lvl = cur;
                win_vec = VW'(i);
            end
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC = DEF_NUM_SRC,
    parameter int LVL_W   = DEF_LVL_W,
    parameter int VEC_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_flag,
    input  logic               cfg_we,
    input  logic [VEC_W-1:0]   cfg_idx,
    input  logic [LVL_W-1:0]   cfg_lvl,
    input  logic               irq_ack,
    output logic               irq_req,
    output logic [LVL_W-1:0]   irq_lvl,
    output logic [VEC_W-1:0]   irq_vec
);
    localparam int LVL_BITS = NUM_SRC * LVL_W;

    typedef struct packed {
        logic [LVL_BITS-1:0] lvl;
        logic [NUM_SRC-1:0]  pend;
        logic [NUM_SRC-1:0]  flag_prev;
        logic                req;
        logic [LVL_W-1:0]    olvl;
        logic [VEC_W-1:0]    ovec;
    } state_t;

    state_t cur_q, nxt_d;

    logic [LVL_BITS-1:0] lvl_d;
    logic [NUM_SRC-1:0]  pend_d;
    logic                win_d;
    logic [LVL_W-1:0]    win_lvl_d;
    logic [VEC_W-1:0]    win_vec_d;

    logic [NUM_SRC-1:0]  pend_q;
    logic [LVL_BITS-1:0] lvl_q;

    irq_level_file #(.N(NUM_SRC), .LW(LVL_W), .VW(VEC_W)) u_lvl (
        .lvl_q (cur_q.lvl),
        .we    (cfg_we),
        .idx   (cfg_idx),
        .val   (cfg_lvl),
        .lvl_d (lvl_d)
    );

    irq_pend_next #(.N(NUM_SRC), .VW(VEC_W)) u_pend (
        .pend_q    (cur_q.pend),
        .flag      (src_flag),
        .flag_prev (cur_q.flag_prev),
        .ack       (irq_ack),
        .shown_req (cur_q.req),
        .shown_vec (cur_q.ovec),
        .pend_d    (pend_d)
    );

    irq_arb #(.N(NUM_SRC), .LW(LVL_W), .VW(VEC_W)) u_arb (
        .pend    (pend_d),
        .lvl     (lvl_d),
        .win     (win_d),
        .win_lvl (win_lvl_d),
        .win_vec (win_vec_d)
    );

    always_comb begin
        nxt_d           = cur_q;
        nxt_d.lvl       = lvl_d;
        nxt_d.pend      = pend_d;
        nxt_d.flag_prev = src_flag;
        nxt_d.req       = win_d;
        nxt_d.olvl      = win_lvl_d;
        nxt_d.ovec      = win_vec_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign pend_q  = cur_q.pend;
    assign lvl_q   = cur_q.lvl;
    assign irq_req = cur_q.req;
    assign irq_lvl = cur_q.olvl;
    assign irq_vec = cur_q.ovec;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
    parameter int N  = 32,
    parameter int LW = 3,
    parameter int VW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [N-1:0]  src_flag,
    input logic          irq_ack,
    input logic          irq_req,
    input logic [LW-1:0] irq_lvl,
    input logic [VW-1:0] irq_vec,
    input logic [N-1:0]  pend_q,
    input logic [N*LW-1:0] lvl_q
);
    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R3: level 0 never presented
    a_r3_no_zero_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_lvl != '0));

    // R1: shown level matches the register of the shown source, which is pending
    a_r1_shown_consistent: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (pend_q[irq_vec] && (irq_lvl == lvl_q[irq_vec*LW +: LW])));

    // R8: nothing stays pending past an edge where its flag was low
    a_r8_withdraw_drops: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((pend_q & ~$past(src_flag)) == '0));

    // R9: acknowledged source is cleared
    a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req) |=> !pend_q[$past(irq_vec)]);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.N(NUM_SRC), .LW(LVL_W), .VW(VEC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_flag (src_flag),
    .irq_ack  (irq_ack),
    .irq_req  (irq_req),
    .irq_lvl  (irq_lvl),
    .irq_vec  (irq_vec),
    .pend_q   (pend_q),
    .lvl_q    (lvl_q)
);

// File: tb/prio_irq_ctrl_test.sv
`timescale 1ns/1ps
module prio_irq_ctrl_test;
    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src_flag = '0;
    logic         cfg_we = 1'b0;
    logic [4:0]   cfg_idx = '0;
    logic [2:0]   cfg_lvl = '0;
    logic         irq_ack = 1'b0;
    logic         irq_req;
    logic [2:0]   irq_lvl;
    logic [4:0]   irq_vec;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int  m_lvl  [N];
    bit  m_pend [N];
    bit  m_prev [N];
    bit  e_req;
    int  e_lvl;
    int  e_vec;

    always #4 clk = ~clk;

    prio_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .src_flag(src_flag), .cfg_we(cfg_we),
        .cfg_idx(cfg_idx), .cfg_lvl(cfg_lvl), .irq_ack(irq_ack),
        .irq_req(irq_req), .irq_lvl(irq_lvl), .irq_vec(irq_vec)
    );

    task automatic check(input string tag);
        checks++;
        if (irq_req !== e_req || int'(irq_lvl) != e_lvl || int'(irq_vec) != e_vec) begin
            fails++;
            $display("FAIL %s: got req=%0d lvl=%0d vec=%0d, expected req=%0d lvl=%0d vec=%0d",
                     tag, irq_req, irq_lvl, irq_vec, e_req, e_lvl, e_vec);
        end
    endtask

    // One clock: drive inputs, advance model, compare at the falling edge.
    task automatic cyc(input logic [N-1:0] f, input bit we, input int idx,
                       input int v, input bit ack, input string tag);
        int clr;
        src_flag = f;
        cfg_we   = we;
        cfg_idx  = 5'(idx);
        cfg_lvl  = 3'(v);
        irq_ack  = ack;
        @(posedge clk);
        if (we) m_lvl[idx] = v;
        clr = (ack && e_req) ? e_vec : -1;
        for (int i = 0; i < N; i++) begin
            m_pend[i] = (m_pend[i] || (f[i] && !m_prev[i])) && f[i] && (i != clr);
            m_prev[i] = f[i];
        end
        e_req = 0; e_lvl = 0; e_vec = 0;
        for (int i = 0; i < N; i++) begin
            if (m_pend[i] && m_lvl[i] > e_lvl) begin
                e_req = 1; e_lvl = m_lvl[i]; e_vec = i;
            end
        end
        @(negedge clk);
        cfg_we  = 0;
        irq_ack = 0;
        check(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] cur;
        logic [31:0]  lf;
        for (int i = 0; i < N; i++) begin m_lvl[i] = 0; m_pend[i] = 0; m_prev[i] = 0; end
        e_req = 0; e_lvl = 0; e_vec = 0;
        repeat (3) @(negedge clk);
        check("R2 reset outputs");
        rst_n = 1;
        @(negedge clk);
        check("R2 after reset release");

        // R3: all levels 0, every flag raised, nothing shown
        cyc('1, 0, 0, 0, 0, "R3 all flags level0");
        cyc('1, 0, 0, 0, 1, "R3 ack with nothing shown");
        cyc('0, 0, 0, 0, 0, "R8 flags dropped");

        // R1/R4/R9 sweep every source at every level
        for (int s = 0; s < N; s++) begin
            for (int v = 1; v < 8; v++) begin
                cyc('0, 1, s, v, 0, "R1 level write");
                cyc(N'(1) << s, 0, 0, 0, 0, "R4 single source shown");
                cyc(N'(1) << s, 0, 0, 0, 1, "R9 ack clears");
                cyc(N'(1) << s, 0, 0, 0, 0, "R9 no re-pend while high");
                cyc('0, 0, 0, 0, 0, "R8 idle");
            end
            cyc('0, 1, s, 0, 0, "R1 level back to 0");
        end

        // R4/R5/R6: mixed levels, all rise together, drain by ack
        for (int s = 0; s < N; s++) cyc('0, 1, s, (s * 5 + 3) % 8, 0, "R1 pattern write");
        cyc('1, 0, 0, 0, 0, "R5 tie lowest vector");
        for (int k = 0; k < N; k++) cyc('1, 0, 0, 0, 1, "R6 drain held order");
        cyc('0, 0, 0, 0, 0, "R8 release");

        // R7 preemption, then the held one returns
        cyc(N'(1) << 10, 1, 10, 2, 0, "R7 low cause shown");
        cyc((N'(1) << 10) | (N'(1) << 20), 1, 20, 6, 0, "R7 preempted");
        cyc((N'(1) << 10) | (N'(1) << 20), 0, 0, 0, 1, "R6 held returns");
        // R1: raise level of shown source live
        cyc((N'(1) << 10) | (N'(1) << 20), 1, 10, 7, 0, "R1 live level change");
        // R8 withdraw shown source
        cyc(N'(1) << 20, 0, 0, 0, 0, "R8 withdraw shown");
        cyc('0, 0, 0, 0, 0, "R10 empty zeros");

        // R10 pseudo-random run
        lf = 32'hACE1_2468;
        cur = '0;
        for (int t = 0; t < 4000; t++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            cur = cur ^ (N'(1) << lf[4:0]);
            if (lf[9:8] == 2'b00) cur = cur ^ (N'(1) << lf[14:10]);
            cyc(cur, lf[17:15] == 3'b000, int'(lf[22:18]), int'(lf[25:23]),
                lf[27:26] == 2'b00, "R10 random");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule